// File: doc/BRIEF.md
# Wake-up frame pattern filter

This block sits beside a receive path and watches each Ethernet frame one byte at a time. It holds a small bank of independent pattern filters. Each filter picks a sparse set of byte positions with a 31-bit mask that is anchored at a programmable byte offset. It runs a CRC-16 over only the chosen bytes and compares the result with a programmed 16-bit value. A filter can also be limited to unicast or to multicast destinations, and it can be switched off.

The receive side supplies a byte strobe, a start marker on the first destination-address byte, an end marker on the last byte, and a frame-good flag that is valid with the end marker. Configuration arrives over a one-cycle write port. A new setting is staged and only becomes active at the next frame start, so a frame in flight is always judged against one consistent setting. When a good frame ends and at least one filter agrees, a single-cycle wake pulse is raised. A per-filter flag vector reports which filters agreed.

Top module: `wake_pattern_filter`

## Requirements
- R1: After reset, `wake_o` is 0 and every bit of `match_o` is 0.
- R2: A filter's digest starts at 0xFFFF at each frame start. Each selected byte is folded in least significant bit first: the shifted-out top bit XOR the data bit decides whether polynomial 0x8005 is applied. No final inversion is applied. The filter agrees only when this digest equals its programmed 16-bit value.
- R3: Byte positions count from 0 at the first destination-address byte. Mask bit j (j = 0..30) selects the byte at position offset + j, and every other byte is skipped. Writing a 1 to mask bit 31 has no effect on the selection.
- R4: Command bit 0 enables a filter. A filter with this bit clear never sets its `match_o` bit.
- R5: Command bit 1 selects the address type: 1 means multicast only and 0 means unicast only. A frame is multicast when bit 0 of its position-0 byte is 1.
- R6: Results are decided only on a frame end with `good_i` high. A frame end with `good_i` low leaves `wake_o` low and `match_o` unchanged.
- R7: In the cycle after a good frame end, `match_o` holds that frame's per-filter results, with non-agreeing bits cleared. `wake_o` is high for exactly that one cycle when any bit is set. `match_o` then holds until the next good frame end.
- R8: A frame that ends before offset + 30 is judged on the masked bytes that actually arrived.
- R9: A write made while a frame is in progress, or in its start cycle, does not affect that frame. It takes effect from the next frame start.
- R10: `wr_addr_i` is {filter index, field}. Field 0 is the mask (data bits 30:0), 1 is the offset (low OFS_W bits), 2 is the command and 3 is the expected CRC (bits 15:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | A frame byte is present on byte_i |
| byte_i | input | 8 | Frame byte |
| sof_i | input | 1 | With byte_vld_i: this byte is the first destination-address byte |
| eof_i | input | 1 | Frame ends; the byte present in this cycle is included |
| good_i | input | 1 | Frame passed receive checks, valid with eof_i |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | $clog2(N_FILT)+2 | {filter index, field} |
| wr_data_i | input | 32 | Write data |
| wake_o | output | 1 | One-cycle wake event |
| match_o | output | N_FILT | Per-filter result of the latest good frame |

## Verification
Two events can meet in one cycle: a configuration write and a frame that is being received. The bench provokes this by issuing a write to the very filter being judged on the third byte of a frame, changing either the expected digest or the enable. That frame must still agree under its old setting, and the next identical frame must give the new result. A second overlap puts the frame end on the same cycle as the last byte. Every sweep frame is sent this way, so the final byte must enter the digest before the comparison in the same clock.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int MASK_W = 31;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam int CMD_EN_BIT = 0;
  localparam int CMD_MC_BIT = 1;

  typedef enum logic [1:0] {
    FLD_MASK = 2'd0,
    FLD_OFS  = 2'd1,
    FLD_CMD  = 2'd2,
    FLD_CRC  = 2'd3
  } fld_e;

  // lsb-first fold of one byte
  function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[CRC_W-1] ^ d[b]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/wpf_regs.sv
module wpf_regs
  import wpf_pkg::*;
#(
  parameter int N_FILT = 4,
  parameter int OFS_W  = 8,
  localparam int FW = (N_FILT > 1) ? $clog2(N_FILT) : 1,
  localparam int AW = FW + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [AW-1:0]                  wr_addr_i,
  input  logic [31:0]                    wr_data_i,
  input  logic                           load_i,
  output logic [N_FILT-1:0][MASK_W-1:0]  mask_o,
  output logic [N_FILT-1:0][OFS_W-1:0]   ofs_o,
  output logic [N_FILT-1:0]              en_o,
  output logic [N_FILT-1:0]              mc_sel_o,
  output logic [N_FILT-1:0][CRC_W-1:0]   crc_o
);
  logic unused_data;
  assign unused_data = ^wr_data_i;

  for (genvar g = 0; g < N_FILT; g++) begin : g_flt
    logic [MASK_W-1:0] pm_q, am_q;
    logic [OFS_W-1:0]  po_q, ao_q;
    logic              pe_q, ae_q, pc_q, ac_q;
    logic [CRC_W-1:0]  pk_q, ak_q;
    logic              sel;

    assign sel = wr_en_i && (wr_addr_i[AW-1:2] == FW'(g));

    // staged copy, written any time
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pm_q <= '0;
        po_q <= '0;
        pe_q <= 1'b0;
        pc_q <= 1'b0;
        pk_q <= '0;
      end else if (sel) begin
        case (fld_e'(wr_addr_i[1:0]))
          FLD_MASK: pm_q <= wr_data_i[MASK_W-1:0];
          FLD_OFS:  po_q <= wr_data_i[OFS_W-1:0];
          FLD_CMD: begin
            pe_q <= wr_data_i[CMD_EN_BIT];
            pc_q <= wr_data_i[CMD_MC_BIT];
          end
          FLD_CRC:  pk_q <= wr_data_i[CRC_W-1:0];
          default: ;
        endcase
      end
    end

    // active copy, frozen for the frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        am_q <= '0;
        ao_q <= '0;
        ae_q <= 1'b0;
        ac_q <= 1'b0;
        ak_q <= '0;
      end else if (load_i) begin
        am_q <= pm_q;
        ao_q <= po_q;
        ae_q <= pe_q;
        ac_q <= pc_q;
        ak_q <= pk_q;
      end
    end

    assign mask_o[g]   = load_i ? pm_q : am_q;
    assign ofs_o[g]    = load_i ? po_q : ao_q;
    assign en_o[g]     = load_i ? pe_q : ae_q;
    assign mc_sel_o[g] = load_i ? pc_q : ac_q;
    assign crc_o[g]    = load_i ? pk_q : ak_q;
  end
endmodule

// File: rtl/wpf_frame.sv
module wpf_frame #(
  parameter int POS_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             vld_i,
  input  logic             eof_i,
  input  logic             bit0_i,
  output logic             sof_o,
  output logic             take_o,
  output logic             decide_o,
  output logic [POS_W-1:0] pos_o,
  output logic             mc_o
);
  logic             in_q;
  logic             mc_q;
  logic [POS_W-1:0] pos_q;

  assign sof_o    = sof_i && vld_i;
  assign take_o   = vld_i && (sof_i || in_q);
  assign decide_o = eof_i && (sof_o || in_q);
  assign pos_o    = sof_o ? '0 : pos_q;
  assign mc_o     = sof_o ? bit0_i : mc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      mc_q  <= 1'b0;
      pos_q <= '0;
    end else begin
      if (sof_o) begin
        in_q <= 1'b1;
        mc_q <= bit0_i;
      end
      if (take_o && (pos_o != '1)) pos_q <= pos_o + 1'b1;
      else if (sof_o)              pos_q <= pos_o;
      if (decide_o) in_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wpf_lane.sv
module wpf_lane
  import wpf_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int POS_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              en_i,
  input  logic              mc_sel_i,
  input  logic              mc_i,
  input  logic [CRC_W-1:0]  crc_exp_i,
  output logic              hit_o
);
  logic [POS_W-1:0] ofs_ext, rel;
  logic             in_win, sel;
  logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;

  assign ofs_ext  = POS_W'(ofs_i);
  assign rel      = pos_i - ofs_ext;
  assign in_win   = (pos_i >= ofs_ext) && (rel < POS_W'(MASK_W));
  assign sel      = take_i && in_win && mask_i[rel[4:0]];
  assign crc_base = sof_i ? CRC_SEED : crc_q;
  assign crc_nxt  = sel ? crc16_step(crc_base, byte_i) : crc_base;
  assign hit_o    = en_i && (mc_sel_i == mc_i) && (crc_nxt == crc_exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (take_i) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
  import wpf_pkg::*;
#(
  parameter int N_FILT = 4,
  parameter int OFS_W  = 8,
  parameter int POS_W  = 12,
  localparam int FW = (N_FILT > 1) ? $clog2(N_FILT) : 1,
  localparam int AW = FW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              good_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              wake_o,
  output logic [N_FILT-1:0] match_o
);
  logic                          sof_v, take, decide, mc;
  logic [POS_W-1:0]              pos;
  logic [N_FILT-1:0][MASK_W-1:0] mask;
  logic [N_FILT-1:0][OFS_W-1:0]  ofs;
  logic [N_FILT-1:0][CRC_W-1:0]  crc_exp;
  logic [N_FILT-1:0]             en_eff, mc_sel, hits;
  logic                          wake_q;
  logic [N_FILT-1:0]             match_q;

  wpf_frame #(.POS_W(POS_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sof_i    (sof_i),
    .vld_i    (byte_vld_i),
    .eof_i    (eof_i),
    .bit0_i   (byte_i[0]),
    .sof_o    (sof_v),
    .take_o   (take),
    .decide_o (decide),
    .pos_o    (pos),
    .mc_o     (mc)
  );

  wpf_regs #(.N_FILT(N_FILT), .OFS_W(OFS_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (sof_v),
    .mask_o    (mask),
    .ofs_o     (ofs),
    .en_o      (en_eff),
    .mc_sel_o  (mc_sel),
    .crc_o     (crc_exp)
  );

  for (genvar g = 0; g < N_FILT; g++) begin : g_lane
    wpf_lane #(.OFS_W(OFS_W), .POS_W(POS_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sof_i     (sof_v),
      .take_i    (take),
      .byte_i    (byte_i),
      .pos_i     (pos),
      .mask_i    (mask[g]),
      .ofs_i     (ofs[g]),
      .en_i      (en_eff[g]),
      .mc_sel_i  (mc_sel[g]),
      .mc_i      (mc),
      .crc_exp_i (crc_exp[g]),
      .hit_o     (hits[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q  <= 1'b0;
      match_q <= '0;
    end else begin
      wake_q <= decide && good_i && (|hits);
      if (decide && good_i) match_q <= hits;
    end
  end

  assign wake_o  = wake_q;
  assign match_o = match_q;
endmodule

// File: rtl/wpf_chk.sv
module wpf_chk #(
  parameter int N_FILT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              decide_i,
  input logic              good_i,
  input logic [N_FILT-1:0] en_eff_i,
  input logic              wake_o,
  input logic [N_FILT-1:0] match_o
);
  // R7
  wake_has_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (match_o != '0));

  // R6
  wake_after_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(decide_i && good_i));

  // R6
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(decide_i && good_i) |-> $stable(match_o));

  // R4
  disabled_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(decide_i && good_i) |-> ((match_o & ~$past(en_eff_i)) == '0));
endmodule

bind wake_pattern_filter wpf_chk #(.N_FILT(N_FILT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .decide_i (decide),
  .good_i   (good_i),
  .en_eff_i (en_eff),
  .wake_o   (wake_o),
  .match_o  (match_o)
);

// File: tb/wake_pattern_filter_tb.sv
module wake_pattern_filter_tb_top;
  localparam int CLK_NS = 10;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 0, sof = 0, eof = 0, good = 0, wr_en = 0;
  logic [7:0]  bt = '0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wake;
  logic [3:0]  match;

  always #(CLK_NS/2) clk = ~clk;

  wake_pattern_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .byte_i(bt),
    .sof_i(sof), .eof_i(eof), .good_i(good), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wake_o(wake), .match_o(match)
  );

  int total = 0, bad = 0;
  logic [7:0]  fb [64];
  logic [30:0] m_mask [NF];
  int          m_ofs [NF];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(logic [15:0] c, logic [7:0] d);
    int v;
    v = c;
    for (int b = 0; b < 8; b++) begin
      int t;
      t = ((v >> 15) & 1) ^ ((d >> b) & 1);
      v = (v << 1) & 16'hFFFF;
      if (t != 0) v = v ^ 16'h8005;
    end
    return 16'(v);
  endfunction

  function automatic logic [15:0] model_crc(int f, int len);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < len; k++) begin
      int j;
      j = k - m_ofs[f];
      if (j >= 0 && j < 31 && m_mask[f][j]) c = step(c, fb[k]);
    end
    return c;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  // R10: address {filter, field}
  task automatic prog_cfg(int f, logic [31:0] mask, int ofs, bit en, bit mc);
    m_mask[f] = mask[30:0];
    m_ofs[f]  = ofs;
    wr(f*4 + 0, mask);
    wr(f*4 + 1, 32'(ofs));
    wr(f*4 + 2, {30'd0, mc, en});
  endtask

  task automatic prog_crc(int f, logic [15:0] c);
    wr(f*4 + 3, {16'd0, c});
  endtask

  task automatic fill(int len, int seed, bit mc);
    for (int k = 0; k < len; k++) fb[k] = 8'((k*37 + seed*11 + 5) & 255);
    fb[0][0] = mc;
  endtask

  task automatic send(int len, bit gd, bit mw, int mw_a, logic [31:0] mw_d);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      vld = 1; bt = fb[k]; sof = (k == 0); eof = (k == len-1); good = gd;
      wr_en = mw && (k == 2); wr_addr = 4'(mw_a); wr_data = mw_d;
    end
    @(negedge clk);
    vld = 0; sof = 0; eof = 0; good = 0; wr_en = 0;
  endtask

  initial begin
    #(CLK_NS*150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int offs[3];
    logic [31:0] masks[4];
    int lens[2];
    int seed;
    logic [15:0] c;
    logic [3:0] prev;
    offs = '{0, 3, 12};
    masks = '{32'h1, 32'h7FFFFFFF, 32'h5A5, 32'h40000001};
    lens = '{16, 40};
    seed = 1;
    repeat (3) @(negedge clk);
    chk("R1 wake", 32'(wake), 0);
    chk("R1 match", 32'(match), 0);
    rst_n = 1;

    // sweep: f agrees, f+1 wrong digest, f+2 wrong type, f+3 disabled
    for (int f = 0; f < NF; f++)
      for (int oi = 0; oi < 3; oi++)
        for (int mi = 0; mi < 4; mi++)
          for (int li = 0; li < 2; li++) begin
            bit mc;
            mc = 1'((f + oi + mi + li) % 2);
            fill(lens[li], seed, mc); seed++;
            for (int q = 0; q < NF; q++) begin
              int idx;
              idx = (f + q) % NF;
              prog_cfg(idx, masks[mi], offs[oi], q != 3, (q == 2) ? !mc : mc);
              c = model_crc(idx, lens[li]);
              prog_crc(idx, (q == 1) ? c ^ 16'h1 : c);
            end
            send(lens[li], 1, 0, 0, 0);
            chk("R2 R3 R4 R5 match", 32'(match), 32'(1 << f));
            chk("R7 wake", 32'(wake), 1);
            @(negedge clk);
            chk("R7 pulse", 32'(wake), 0);
          end

    // R6: bad frame leaves flags alone
    prev = match;
    send(lens[1], 0, 0, 0, 0);
    chk("R6 hold", 32'(match), 32'(prev));
    chk("R6 wake", 32'(wake), 0);
    for (int f = 0; f < NF; f++) wr(f*4 + 2, 0);
    send(lens[1], 1, 0, 0, 0);
    chk("R4 all off", 32'(match), 0);
    chk("R7 no wake", 32'(wake), 0);

    // R8: short frame
    fill(5, 77, 0);
    prog_cfg(0, 32'h7FFFFFFF, 3, 1, 0);
    prog_crc(0, model_crc(0, 5));
    send(5, 1, 0, 0, 0);
    chk("R8 short", 32'(match), 1);

    // R3: mask bit 31 written has no effect
    fill(40, 91, 1);
    prog_cfg(1, 32'hFFFFFFFF, 0, 1, 1);
    prog_crc(1, model_crc(1, 40));
    send(40, 1, 0, 0, 0);
    chk("R3 bit31", 32'(match), 2);

    // R9: mid-frame write to digest, then to enable
    fill(20, 5, 0);
    prog_cfg(2, 32'h00FF00F, 2, 1, 0);
    c = model_crc(2, 20);
    prog_crc(2, c);
    send(20, 1, 1, 2*4 + 3, {16'd0, c ^ 16'h8000});
    chk("R9 old used", 32'(match), 4);
    send(20, 1, 0, 0, 0);
    chk("R9 new used", 32'(match), 0);
    prog_crc(2, c);
    send(20, 1, 1, 2*4 + 2, 32'd0);
    chk("R9 en old", 32'(match), 4);
    chk("R9 wake", 32'(wake), 1);
    send(20, 1, 0, 0, 0);
    chk("R9 en new", 32'(match), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule